// File: doc/BRIEF.md
# Soft-Reset Handshake Sequencer

This block drives the module-reset handshake of a peripheral whose registers come in groups of four 32-bit words: a direct word, a set alias, a clear alias and a toggle alias. In the set and clear aliases, every 1 bit written sets or clears the matching bit of the direct word. The peripheral's first register holds a soft-reset control in bit 31 and a clock-gate control in bit 30.

A one-cycle start pulse and a base address launch the sequence. The sequencer then acts as a master on a simple request/acknowledge register bus. It runs five fixed steps, and each step writes one mask to an alias address. Four of the steps then wait a fixed number of settle cycles and read the direct word until the watched bit reaches its target. Each poll is bounded. When every step completes, the block raises a done pulse. When a poll runs out of reads, it raises an error pulse and abandons the rest of the sequence.

A transfer completes in a cycle where `bus_req` and `bus_ack` are both high.

Top module: `srst_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until a start is accepted, `busy`, `done`, `fail` and `bus_req` are all low.
- R2: A `start` pulse seen while `busy` is low is accepted, and `busy` is high in the next cycle. A `start` pulse seen while `busy` is high is ignored: the running sequence keeps its base address and ends once, and no second sequence follows.
- R3: An accepted sequence issues these writes (`bus_we`=1) in this order:
  1. base+0x8 with data 0x8000_0000.
  2. base+0x8 with data 0x4000_0000.
  3. base+0x4 with data 0x8000_0000.
  4. base+0x8 with data 0x8000_0000.
  5. base+0x8 with data 0x4000_0000.
- R4: After write 2 there is no poll. After writes 1, 3, 4 and 5, the block reads base+0x0 (`bus_we`=0) until the read data shows, respectively, bit 31 = 0, bit 30 = 1, bit 31 = 0 and bit 30 = 0. All other read-data bits are ignored. The first matching read ends the poll.
- R5: Between the completion of a write that starts a poll and the start of that poll's first read, `bus_req` is low for exactly SETTLE_CYCLES cycles (default 16). Write 3 follows the completion of write 2 with no idle cycle in between.
- R6: The number of reads in a poll equals the position of the first matching read. A match on read number POLL_LIMIT (default 1024), the last one allowed, still lets the sequence proceed.
- R7: If POLL_LIMIT reads of a poll all fail to match, `fail` pulses and no further bus access or write of the sequence follows.
- R8: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` remain unchanged in the next cycle.
- R9: `done` and `fail` are never high together. Each pulses for exactly one cycle, with `done` following the match of the last poll. `busy` stays high through that cycle and is low in the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin the handshake |
| start_base | input | AW | Base address of the target register group, taken with `start` |
| busy | output | 1 | High from the cycle after an accepted start through the end pulse |
| done | output | 1 | One-cycle pulse: the handshake completed |
| fail | output | 1 | One-cycle pulse: a poll ran out of reads |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Slave acknowledge; completes the current transfer |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` on a read |

## Verification
A wrong step index shows up at the ports on the very next write, as a wrong alias offset or a wrong mask. It also shows up as a poll waiting on the wrong bit, which ends early or runs into a timeout. A poll counter that is off becomes visible at the end of the affected poll, as a read count one higher or lower than the target model allows, or as a `fail` where `done` belongs. A faulty settle counter shows at the first read after the write, as an idle gap of the wrong length. A stuck state register shows as a missing or repeated end pulse within a cycle of the final transfer.

// File: rtl/srst_pkg.sv
package srst_pkg;

  localparam int DATA_W    = 32;
  localparam int NUM_STEPS = 5;
  localparam int STEP_W    = 3;

  // alias offsets inside one register group
  localparam logic [3:0] OFF_SET = 4'h4;
  localparam logic [3:0] OFF_CLR = 4'h8;

  localparam logic [4:0] BIT_SRST = 5'd31;
  localparam logic [4:0] BIT_GATE = 5'd30;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_SETTLE,
    ST_READ,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  // one step: write a mask to an alias, optionally poll a bit for a value
  typedef struct packed {
    logic [3:0] off;
    logic [4:0] wbit;
    logic       polls;
    logic [4:0] pbit;
    logic       want;
  } step_t;

  function automatic step_t step_desc(input logic [STEP_W-1:0] idx);
    step_t d;
    case (idx)
      3'd1:    d = '{OFF_CLR, BIT_GATE, 1'b0, BIT_GATE, 1'b0};
      3'd2:    d = '{OFF_SET, BIT_SRST, 1'b1, BIT_GATE, 1'b1};
      3'd3:    d = '{OFF_CLR, BIT_SRST, 1'b1, BIT_SRST, 1'b0};
      3'd4:    d = '{OFF_CLR, BIT_GATE, 1'b1, BIT_GATE, 1'b0};
      default: d = '{OFF_CLR, BIT_SRST, 1'b1, BIT_SRST, 1'b0};
    endcase
    return d;
  endfunction

  function automatic logic [DATA_W-1:0] bit_mask(input logic [4:0] pos);
    return DATA_W'(1) << pos;
  endfunction

endpackage

// File: rtl/srst_count.sv
module srst_count #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (inc)    cnt_q <= cnt_q + CW'(1);
  end

  assign at_last = (cnt_q == CW'(LIMIT - 1));

  // R6: a poll never counts past its bound
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/srst_bus_port.sv
module srst_bus_port
  import srst_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_wr,
  input  logic              issue_rd,
  input  logic [AW-1:0]     base,
  input  step_t             desc,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              ev_wr_done,
  output logic              ev_rd_done,
  output logic              ev_match
);

  function automatic logic [AW-1:0] alias_addr(input logic [AW-1:0] b, input logic [3:0] off);
    return b + AW'(off);
  endfunction

  logic polled_bit;

  assign bus_req    = issue_wr | issue_rd;
  assign bus_we     = issue_wr;
  assign bus_addr   = issue_wr ? alias_addr(base, desc.off) : base;
  assign bus_wdata  = issue_wr ? bit_mask(desc.wbit) : '0;
  assign ev_wr_done = issue_wr & bus_ack;
  assign ev_rd_done = issue_rd & bus_ack;
  assign polled_bit = bus_rdata[desc.pbit];
  assign ev_match   = (polled_bit == desc.want);

  // R8: an unacknowledged access holds still
  a_r8_hold_access: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata)));

endmodule

// File: rtl/srst_seq.sv
module srst_seq
  import srst_pkg::*;
#(
  parameter int AW            = 32,
  parameter int SETTLE_CYCLES = 16,
  parameter int POLL_LIMIT    = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_base,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic              bus_req,
  output logic              bus_we,
  output logic [AW-1:0]     bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ack,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q;
  logic [STEP_W-1:0] step_q;
  logic [AW-1:0]     base_q;
  step_t             desc;

  // named internal events
  logic ev_accept, ev_wr_done, ev_rd_done, ev_match;
  logic ev_settled, ev_poll_last, ev_timeout, ev_last_step, ev_advance;
  logic in_settle;

  assign desc         = step_desc(step_q);
  assign busy         = (state_q != ST_IDLE);
  assign done         = (state_q == ST_DONE);
  assign fail         = (state_q == ST_FAIL);
  assign in_settle    = (state_q == ST_SETTLE);
  assign ev_accept    = start && !busy;
  assign ev_last_step = (step_q == LAST_STEP);
  assign ev_advance   = (ev_wr_done && !desc.polls) || (ev_rd_done && ev_match);
  assign ev_timeout   = ev_rd_done && !ev_match && ev_poll_last;

  srst_bus_port #(.AW(AW)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_wr   (state_q == ST_WRITE),
    .issue_rd   (state_q == ST_READ),
    .base       (base_q),
    .desc       (desc),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .ev_wr_done (ev_wr_done),
    .ev_rd_done (ev_rd_done),
    .ev_match   (ev_match)
  );

  srst_count #(.LIMIT(SETTLE_CYCLES)) u_settle (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ev_wr_done),
    .inc     (in_settle && !ev_settled),
    .at_last (ev_settled)
  );

  srst_count #(.LIMIT(POLL_LIMIT)) u_polls (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (in_settle),
    .inc     (ev_rd_done),
    .at_last (ev_poll_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      base_q  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (ev_accept) begin
          base_q  <= start_base;
          step_q  <= '0;
          state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (ev_advance) begin
            if (ev_last_step) state_q <= ST_DONE;
            else begin
              step_q  <= step_q + STEP_W'(1);
              state_q <= ST_WRITE;
            end
          end else if (ev_wr_done) state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (ev_settled) state_q <= ST_READ;
        ST_READ: begin
          if (ev_advance) begin
            if (ev_last_step) state_q <= ST_DONE;
            else begin
              step_q  <= step_q + STEP_W'(1);
              state_q <= ST_WRITE;
            end
          end else if (ev_timeout) state_q <= ST_FAIL;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9: end pulses exclusive, single-cycle, and followed by idle
  a_r9_end_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fail) |=> !busy);
  // R2: an accepted start raises busy
  a_r2_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R7: no access during the error pulse
  a_r7_quiet_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !bus_req);

endmodule

// File: tb/sim_srst_seq.sv
module sim_srst_seq;
  import srst_pkg::*;

  localparam int AW     = 32;
  localparam int SETTLE = 16;
  localparam int LIMIT  = 1024;
  localparam int K_WR = 0, K_RD = 1, K_DONE = 2, K_FAIL = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [AW-1:0]     start_base = '0;
  logic              busy, done, fail, bus_req, bus_we;
  logic [AW-1:0]     bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;

  always #4 clk = ~clk;   // 125 MHz

  srst_seq #(.AW(AW), .SETTLE_CYCLES(SETTLE), .POLL_LIMIT(LIMIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .start_base(start_base),
    .busy(busy), .done(done), .fail(fail),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  typedef struct {
    int            kind;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    int            n;
  } exp_t;

  exp_t expq[$];
  int checks = 0, errors = 0;

  // target model
  int            hold_cfg [5];
  int            ack_wait = 0;
  int            hold31 = 0, hold30 = 0;
  logic          tgt31 = 1'b1, tgt30 = 1'b1;
  int            wr_idx = 0;
  logic [AW-1:0] cur_base = '0;
  // monitor
  int wcnt = 0, rd_run = 0, gap = 0, last_kind = -1;
  bit rd_addr_ok = 1'b1, end_seen = 1'b0, post_chk = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input int kind, input logic [AW-1:0] a, input logic [31:0] d, input int n);
    exp_t e;
    e.kind = kind; e.addr = a; e.data = d; e.n = n;
    expq.push_back(e);
  endtask

  task automatic observe(input int kind, input logic [AW-1:0] a, input logic [31:0] d, input int n);
    exp_t e;
    string tag;
    if (expq.size() == 0) begin
      check(1'b0, "R3", "event with nothing expected", kind, -1);
      return;
    end
    e = expq.pop_front();
    tag = (kind >= K_DONE || e.kind >= K_DONE) ? "R7" : "R3";
    check(kind == e.kind, tag, "event kind", kind, e.kind);
    if (kind == e.kind && kind == K_WR) begin
      check(a == e.addr, "R3", "write address", a, e.addr);
      check(d == e.data, "R3", "write data", d, e.data);
    end
    if (kind == e.kind && kind == K_RD)
      check(n == e.n, "R6", "reads in poll", n, e.n);
  endtask

  task automatic flush_reads();
    if (rd_run > 0) begin
      check(rd_addr_ok, "R4", "poll reads at base+0x0", rd_addr_ok, 1);
      observe(K_RD, '0, '0, rd_run);
      rd_run = 0;
    end
  endtask

  task automatic serve();
    logic [AW-1:0] off;
    logic v31, v30;
    if (bus_we) begin
      flush_reads();
      if (last_kind == K_WR) check(gap == 0, "R5", "idle cycles between writes 2 and 3", gap, 0);
      observe(K_WR, bus_addr, bus_wdata, 0);
      off = bus_addr - cur_base;
      if (off == AW'(8)) begin
        if (bus_wdata[31]) begin tgt31 = 1'b0; hold31 = hold_cfg[wr_idx % 5]; end
        if (bus_wdata[30]) begin tgt30 = 1'b0; hold30 = hold_cfg[wr_idx % 5]; end
      end else if (off == AW'(4) && bus_wdata[31]) begin
        tgt31 = 1'b1; hold31 = 0;
        tgt30 = 1'b1; hold30 = hold_cfg[wr_idx % 5];
      end
      wr_idx++;
      gap = 0;
      last_kind = K_WR;
    end else begin
      if (rd_run == 0) begin
        check(gap == SETTLE, "R5", "idle cycles before first poll read", gap, SETTLE);
        rd_addr_ok = 1'b1;
      end
      if (bus_addr != cur_base) rd_addr_ok = 1'b0;
      v31 = (hold31 > 0) ? ~tgt31 : tgt31;
      v30 = (hold30 > 0) ? ~tgt30 : tgt30;
      if (hold31 > 0) hold31--;
      if (hold30 > 0) hold30--;
      bus_rdata = {v31, v30, 30'h25A5A5A5};
      rd_run++;
      last_kind = K_RD;
    end
  endtask

  // slave model and monitor, on the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; wcnt = 0; rd_run = 0; gap = 0;
    end else begin
      if (post_chk) begin
        post_chk = 1'b0;
        check(!busy && !done && !fail, "R9", "busy/done/fail after end pulse", {busy, done, fail}, 0);
      end
      if (done || fail) begin
        check(!(done && fail), "R9", "done and fail together", {done, fail}, 0);
        flush_reads();
        observe(done ? K_DONE : K_FAIL, '0, '0, 0);
        end_seen = 1'b1;
        post_chk = 1'b1;
      end
      if (bus_ack) bus_ack = 1'b0;
      else if (bus_req) begin
        if (wcnt < ack_wait) wcnt++;
        else begin
          wcnt = 0;
          bus_ack = 1'b1;
          serve();
        end
      end
      if (!bus_req) gap++;
    end
  end

  task automatic run_case(input string name, input logic [AW-1:0] base,
                          input int h0, input int h1, input int h2, input int h3, input int h4,
                          input int wt, input bit inject);
    int offs [5];
    int bits [5];
    bit polls [5];
    int h [5];
    bit failed;
    int cyc;
    offs = '{8, 8, 4, 8, 8};
    bits = '{31, 30, 31, 31, 30};
    polls = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b1};
    h = '{h0, h1, h2, h3, h4};
    $display("case %s", name);
    @(negedge clk);
    for (int s = 0; s < 5; s++) hold_cfg[s] = h[s];
    ack_wait = wt; tgt31 = 1'b1; tgt30 = 1'b1; hold31 = 0; hold30 = 0;
    wr_idx = 0; last_kind = -1; cur_base = base; end_seen = 1'b0;
    failed = 1'b0;
    for (int s = 0; s < 5; s++) begin
      if (!failed) begin
        push(K_WR, base + AW'(offs[s]), 32'h1 << bits[s], 0);
        if (polls[s]) begin
          if (h[s] + 1 > LIMIT) begin push(K_RD, '0, '0, LIMIT); failed = 1'b1; end
          else push(K_RD, '0, '0, h[s] + 1);
        end
      end
    end
    push(failed ? K_FAIL : K_DONE, '0, '0, 0);
    start = 1'b1; start_base = base;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R2", "busy after accepted start", busy, 1);
    if (inject) begin
      repeat (10) @(negedge clk);
      check(busy == 1'b1, "R2", "busy before ignored start", busy, 1);
      start = 1'b1; start_base = base ^ 32'h00FF_0000;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!end_seen && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!end_seen) check(1'b0, "R7", "watchdog: sequence never ended", cyc, 20000);
    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R3", "expected events left over", expq.size(), 0);
    expq.delete();
    if (inject) begin
      repeat (20) @(negedge clk);
      check(!bus_req && !busy, "R2", "no second sequence after ignored start", {bus_req, busy}, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !bus_req, "R1", "outputs in reset", {busy, done, fail, bus_req}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !bus_req, "R1", "outputs idle after reset", {busy, done, fail, bus_req}, 0);

    run_case("fast target",        32'h8000_0000, 0, 0, 0, 0, 0, 0, 1'b0);
    run_case("slow target, waits", 32'h0004_2100, 3, 0, 7, 2, 5, 2, 1'b1);
    run_case("R7 timeout step 1",  32'h1000_0040, 1024, 0, 0, 0, 0, 0, 1'b0);
    run_case("R6 match on last",   32'h2000_0000, 0, 0, 1023, 0, 0, 1, 1'b0);
    run_case("R7 timeout step 3",  32'h3000_0800, 0, 0, 2000, 0, 0, 0, 1'b0);
    run_case("R7 timeout step 5",  32'h4000_1000, 1, 0, 2, 3, 1024, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule